// File: doc/BRIEF.md
# Writeback Slot Allocator

This block hands out writeback ports to instructions that finish execution in an out-of-order core. It keeps a short calendar of future cycles, each row holding one slot per writeback port. A finishing instruction takes the earliest free slot: the lowest free port of the next cycle, and if that row is taken, the lowest free port of the cycle after, and so on until the window ends. The search starts from the beginning of the window again every cycle. Several execution lanes may finish in the same cycle. They are served in lane order, so a lower lane always gets an earlier slot.

Each clock the window moves forward by one row. The row that reaches the head is read out on the writeback ports. An entry that holds a real result (not squashed, marked executed, no fault) also raises a one-bit wakeup pulse on its port, and the ports report how many such results went out that cycle. Entries without a usable result go out with the wakeup low. A stall output tells execute when the free slots are fewer than the lanes. A completion that finds no room is dropped and reported on a per-lane error output.

Top module: `wbslot_alloc_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, all writeback valid, wakeup and count outputs are zero and the stall output is low.
- R2: A completion presented in cycle t with room in the next row appears on the writeback ports in cycle t+1, with its tag unchanged.
- R3: Within one cycle, lanes are served in ascending lane index. Each served lane takes the lowest free linear slot (row × ports + port) left after the lower lanes have been served, so ports fill from index 0 upward within a row.
- R4: When every port of the next cycle is taken, a completion goes to the first free port of the nearest later cycle in the window, up to the window depth. It then appears on the ports in that later cycle.
- R5: The window advances one row per clock. An entry keeps its port and moves one row closer to the head, and the newly exposed last row starts empty.
- R6: The writeback ports show the head row in port order and stop at the first empty slot. Port p is valid only if ports 0..p-1 are also valid.
- R7: A forwarded entry raises its wakeup bit only if it is not squashed, is marked executed and carries no fault. Any other entry is forwarded with the wakeup bit at 0.
- R8: The count output equals the number of wakeup bits raised in the same cycle.
- R9: The stall output is high exactly when the number of free slots that this cycle's completions can reach is less than the number of lanes. These are the slots of the rows for the next cycle through the cycle depth ahead.
- R10: A valid completion that finds no free slot is not stored. Its bit on the drop output is high in the same cycle. A drop can occur only while stall is high.
- R11: The window never holds more than ports × depth entries. When saturated, it delivers exactly that many results over the following depth cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fin_valid | input | LANES | A lane finishes an instruction this cycle |
| fin_tag | input | LANES×TAG_W | Instruction tag per lane, lane 0 in the low bits |
| fin_squashed | input | LANES | Instruction was squashed |
| fin_executed | input | LANES | Instruction completed execution |
| fin_fault | input | LANES | Instruction carries a fault |
| exec_stall | output | 1 | Too few free slots for all lanes; execute should hold |
| alloc_drop | output | LANES | Completion on this lane found no slot and was lost |
| wb_valid | output | WB_PORTS | Writeback port carries an entry |
| wb_tag | output | WB_PORTS×TAG_W | Tag per writeback port, port 0 in the low bits |
| wb_wake | output | WB_PORTS | Destination-ready wakeup pulse per port |
| wb_count | output | clog2(WB_PORTS+1) | Number of wakeup pulses this cycle |

## Verification
The assertions rely on lane inputs that are known values in every cycle after reset. They do not require execute to honour the stall: drops are checked only against stall, which depends on the window state alone. The stimulus mostly keeps valid low on every lane while stall is high. One phase deliberately ignores stall and drives all lanes each cycle, to saturate the window and force drops. The flag combinations are random, so wakeup gating sees every mix of squashed, executed and fault bits.

// File: rtl/wbslot_pkg.sv
package wbslot_pkg;

    typedef struct packed {
        logic valid;
        logic squashed;
        logic executed;
        logic fault;
    } slot_flags_t;

    function automatic logic result_usable(slot_flags_t f);
        return f.valid && !f.squashed && f.executed && !f.fault;
    endfunction

endpackage

// File: rtl/wbslot_pick.sv
module wbslot_pick #(
    parameter int SLOTS = 6,
    parameter int LANES = 3,
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int FREE_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]            busy,
    input  logic [LANES-1:0]            req,
    output logic [LANES-1:0]            hit,
    output logic [LANES-1:0][IDX_W-1:0] idx,
    output logic [FREE_W-1:0]           free_cnt
);

    logic [SLOTS-1:0] taken;

    // Linear scan from slot 0 each cycle; lanes are served in index order.
    always_comb begin
        taken    = busy;
        hit      = '0;
        idx      = '0;
        free_cnt = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!busy[s]) free_cnt = free_cnt + FREE_W'(1);
        end
        for (int l = 0; l < LANES; l++) begin
            if (req[l]) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (!taken[s] && !hit[l]) begin
                        hit[l]   = 1'b1;
                        idx[l]   = IDX_W'(s);
                        taken[s] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/wbslot_drain.sv
module wbslot_drain
    import wbslot_pkg::*;
#(
    parameter int WB_PORTS = 2,
    parameter int TAG_W    = 6,
    localparam int CNT_W   = $clog2(WB_PORTS + 1)
) (
    input  slot_flags_t [WB_PORTS-1:0]            head_flag,
    input  logic        [WB_PORTS-1:0][TAG_W-1:0] head_tag,
    output logic        [WB_PORTS-1:0]            out_valid,
    output logic        [WB_PORTS-1:0][TAG_W-1:0] out_tag,
    output logic        [WB_PORTS-1:0]            out_wake,
    output logic        [CNT_W-1:0]               out_count
);

    logic run;

    always_comb begin
        run       = 1'b1;
        out_valid = '0;
        out_tag   = '0;
        out_wake  = '0;
        out_count = '0;
        for (int p = 0; p < WB_PORTS; p++) begin
            run          = run && head_flag[p].valid;
            out_valid[p] = run;
            if (run) begin
                out_tag[p]  = head_tag[p];
                out_wake[p] = result_usable(head_flag[p]);
                if (result_usable(head_flag[p])) out_count = out_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wbslot_alloc_top.sv
module wbslot_alloc_top
    import wbslot_pkg::*;
#(
    parameter int WB_PORTS = 2,
    parameter int WB_ROWS  = 3,
    parameter int LANES    = 3,
    parameter int TAG_W    = 6,
    localparam int SLOTS   = WB_PORTS * WB_ROWS,
    localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int FREE_W  = $clog2(SLOTS + 1),
    localparam int CNT_W   = $clog2(WB_PORTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            fin_valid,
    input  logic [LANES*TAG_W-1:0]      fin_tag,
    input  logic [LANES-1:0]            fin_squashed,
    input  logic [LANES-1:0]            fin_executed,
    input  logic [LANES-1:0]            fin_fault,
    output logic                        exec_stall,
    output logic [LANES-1:0]            alloc_drop,
    output logic [WB_PORTS-1:0]         wb_valid,
    output logic [WB_PORTS*TAG_W-1:0]   wb_tag,
    output logic [WB_PORTS-1:0]         wb_wake,
    output logic [CNT_W-1:0]            wb_count
);

    typedef struct packed {
        slot_flags_t [SLOTS-1:0]            flag;
        logic        [SLOTS-1:0][TAG_W-1:0] tag;
    } window_t;

    window_t win_q, win_d, win_sh;

    logic [SLOTS-1:0]            busy_sh;
    logic [LANES-1:0]            grant_hit;
    logic [LANES-1:0][IDX_W-1:0] grant_idx;
    logic [FREE_W-1:0]           free_cnt;
    logic [WB_PORTS-1:0][TAG_W-1:0] tag_out;

    // Window as seen after this edge's advance: row r takes old row r+1.
    always_comb begin
        win_sh = '0;
        for (int i = 0; i < SLOTS - WB_PORTS; i++) begin
            win_sh.flag[i] = win_q.flag[i + WB_PORTS];
            win_sh.tag[i]  = win_q.tag[i + WB_PORTS];
        end
        for (int i = 0; i < SLOTS; i++) busy_sh[i] = win_sh.flag[i].valid;
    end

    wbslot_pick #(
        .SLOTS (SLOTS),
        .LANES (LANES)
    ) u_pick (
        .busy     (busy_sh),
        .req      (fin_valid),
        .hit      (grant_hit),
        .idx      (grant_idx),
        .free_cnt (free_cnt)
    );

    // Next-state computation.
    always_comb begin
        slot_flags_t nf;
        win_d = win_sh;
        for (int l = 0; l < LANES; l++) begin
            nf.valid    = 1'b1;
            nf.squashed = fin_squashed[l];
            nf.executed = fin_executed[l];
            nf.fault    = fin_fault[l];
            if (grant_hit[l]) begin
                win_d.flag[grant_idx[l]] = nf;
                win_d.tag[grant_idx[l]]  = fin_tag[l*TAG_W +: TAG_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign exec_stall = (int'(free_cnt) < LANES);
    assign alloc_drop = fin_valid & ~grant_hit;

    wbslot_drain #(
        .WB_PORTS (WB_PORTS),
        .TAG_W    (TAG_W)
    ) u_drain (
        .head_flag (win_q.flag[WB_PORTS-1:0]),
        .head_tag  (win_q.tag[WB_PORTS-1:0]),
        .out_valid (wb_valid),
        .out_tag   (tag_out),
        .out_wake  (wb_wake),
        .out_count (wb_count)
    );

    assign wb_tag = tag_out;

    // R10
    drop_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|alloc_drop) |-> exec_stall);

    for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
        // R3
        lane_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_valid[l-1] && grant_hit[l]) |-> grant_hit[l-1]);
        // R3
        lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_hit[l] && grant_hit[l-1]) |-> (grant_idx[l] > grant_idx[l-1]));
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot_chk
        if (i % WB_PORTS != 0) begin : g_contig
            // R6
            row_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_q.flag[i].valid |-> win_q.flag[i-1].valid);
        end
        if (i < SLOTS - WB_PORTS) begin : g_shift
            // R5
            row_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(win_q.flag[i+WB_PORTS].valid) |->
                    (win_q.flag[i].valid && win_q.tag[i] == $past(win_q.tag[i+WB_PORTS])));
        end
    end

endmodule

// File: tb/wbslot_alloc_top_test.sv
`timescale 1ns/1ps
module wbslot_alloc_top_test;

    localparam int W  = 2;
    localparam int D  = 3;
    localparam int L  = 3;
    localparam int TW = 6;
    localparam int CW = $clog2(W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [L-1:0]      fin_valid = '0;
    logic [L*TW-1:0]   fin_tag = '0;
    logic [L-1:0]      fin_squashed = '0;
    logic [L-1:0]      fin_executed = '0;
    logic [L-1:0]      fin_fault = '0;
    logic              exec_stall;
    logic [L-1:0]      alloc_drop;
    logic [W-1:0]      wb_valid;
    logic [W*TW-1:0]   wb_tag;
    logic [W-1:0]      wb_wake;
    logic [CW-1:0]     wb_count;

    always #2.5 clk = ~clk;

    wbslot_alloc_top #(.WB_PORTS(W), .WB_ROWS(D), .LANES(L), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .fin_tag(fin_tag),
        .fin_squashed(fin_squashed), .fin_executed(fin_executed), .fin_fault(fin_fault),
        .exec_stall(exec_stall), .alloc_drop(alloc_drop), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .wb_wake(wb_wake), .wb_count(wb_count)
    );

    typedef struct { int due; int tag; bit wake; } ent_t;
    ent_t pend[$];

    int checks = 0;
    int fails  = 0;
    int cur    = 0;
    int seen_valid = 0;
    int next_tag = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cur);
        end
    endtask

    function automatic int due_count(input int c);
        int n = 0;
        foreach (pend[i]) if (pend[i].due == c) n++;
        return n;
    endfunction

    // One cycle: at a falling edge, compare outputs, drive lanes, model allocation.
    // mode 0 idle, 1 sparse, 2 dense honouring stall, 3 all lanes ignoring stall
    task automatic step(input int mode);
        ent_t now_q[$];
        ent_t keep[$];
        int   free_slots;
        bit   exp_stall;
        bit   exp_drop [L];
        int   wakes;
        bit   placed;
        now_q.delete();
        keep.delete();
        foreach (pend[i]) begin
            if (pend[i].due == cur) now_q.push_back(pend[i]);
            else keep.push_back(pend[i]);
        end
        pend = keep;
        wakes = 0;
        for (int p = 0; p < W; p++) begin
            bit ev = (p < now_q.size());
            check(wb_valid[p] == ev, "R6", $sformatf("valid port %0d", p), int'(wb_valid[p]), int'(ev));
            if (ev) begin
                seen_valid++;
                check(int'(wb_tag[p*TW +: TW]) == now_q[p].tag, "R2 R3 R4 R5",
                      $sformatf("tag port %0d", p), int'(wb_tag[p*TW +: TW]), now_q[p].tag);
                check(wb_wake[p] == now_q[p].wake, "R7", $sformatf("wake port %0d", p),
                      int'(wb_wake[p]), int'(now_q[p].wake));
                if (now_q[p].wake) wakes++;
            end else begin
                check(wb_wake[p] == 1'b0, "R7", $sformatf("idle wake port %0d", p), int'(wb_wake[p]), 0);
            end
        end
        check(int'(wb_count) == wakes, "R8", "count", int'(wb_count), wakes);

        free_slots = 0;
        for (int c = cur + 1; c <= cur + D; c++) free_slots += W - due_count(c);
        exp_stall = (free_slots < L);
        check(exec_stall == exp_stall, "R9", "stall", int'(exec_stall), int'(exp_stall));

        for (int l = 0; l < L; l++) begin
            bit v;
            case (mode)
                1:       v = ($urandom_range(0, 9) < 4) && (l == int'($urandom_range(0, L-1)));
                2:       v = !exp_stall && ($urandom_range(0, 9) < 6);
                3:       v = 1'b1;
                default: v = 1'b0;
            endcase
            fin_valid[l]           = v;
            fin_tag[l*TW +: TW]    = TW'(next_tag);
            fin_squashed[l]        = ($urandom_range(0, 9) < 2);
            fin_executed[l]        = ($urandom_range(0, 9) < 8);
            fin_fault[l]           = ($urandom_range(0, 9) < 2);
            next_tag               = (next_tag % ((1 << TW) - 1)) + 1;
        end
        #1;
        for (int l = 0; l < L; l++) begin
            exp_drop[l] = 1'b0;
            if (fin_valid[l]) begin
                placed = 1'b0;
                for (int c = cur + 1; c <= cur + D; c++) begin
                    if (!placed && due_count(c) < W) begin
                        ent_t e;
                        e.due  = c;
                        e.tag  = int'(fin_tag[l*TW +: TW]);
                        e.wake = !fin_squashed[l] && fin_executed[l] && !fin_fault[l];
                        pend.push_back(e);
                        placed = 1'b1;
                    end
                end
                exp_drop[l] = !placed;
            end
            check(alloc_drop[l] == exp_drop[l], "R10", $sformatf("drop lane %0d", l),
                  int'(alloc_drop[l]), int'(exp_drop[l]));
        end
        @(posedge clk);
        cur++;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(wb_valid == '0, "R1", "reset valid", int'(wb_valid), 0);
        check(wb_wake == '0, "R1", "reset wake", int'(wb_wake), 0);
        check(wb_count == '0, "R1", "reset count", int'(wb_count), 0);
        check(exec_stall == 1'b0, "R1", "reset stall", int'(exec_stall), 0);
        rst_n = 1'b1;
        cur = 0;
        check(wb_valid == '0, "R1", "post-reset valid", int'(wb_valid), 0);

        for (int k = 0; k < 60; k++)  step(1);
        for (int k = 0; k < 200; k++) step(2);
        for (int k = 0; k < 15; k++)  step(3);
        seen_valid = 0;
        for (int k = 0; k < D; k++)   step(0);
        check(seen_valid == W * D, "R11", "saturated delivery", seen_valid, W * D);
        for (int k = 0; k < 4; k++)   step(0);
        for (int k = 0; k < 150; k++) step((k % 3 == 0) ? 3 : 2);
        for (int k = 0; k < D + 2; k++) step(0);
        check(pend.size() == 0, "R11", "window drained", pend.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule